// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the basic mode word of an Ethernet PHY. It sits behind a plain parallel register port with an address, a write strobe with write data, and a read strobe with combinational read data. Seven mode fields are held in flops and driven out as separate control outputs: loopback, 100 Mb/s speed select, auto-negotiation enable, low power, isolate, full duplex and collision test. A write of 1 to the auto-negotiation restart bit gives a one-cycle restart request.

Writing 1 to the top bit starts a software reset. A small state machine steps through three states: `RS_IDLE`, `RS_KICK` and `RS_HOLD`. The transition *start* (`RS_IDLE` to `RS_KICK`) is taken on an accepted write with bit 15 set. In that same edge every field is loaded with its default. `RS_KICK` lasts one cycle and raises the idle request for the PHY's other state machines. The transition *settle* (`RS_KICK` to `RS_HOLD`) is taken on the next edge. The transition *finish* (`RS_HOLD` to `RS_IDLE`) is taken when the hold counter runs out. The whole busy period lasts `RST_CYCLES` cycles. During it, bit 15 reads back as 1 and every write is dropped. The default of the isolate field comes from a strapped 5-bit PHY address. A hardware reset loads the defaults at once and has no busy period.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After hardware reset, the register at address `REG_ADDR` (default 0) reads 16'h3400 when `phy_addr` is 0. In that word speed is bit 13, auto-negotiation enable is bit 12 and isolate is bit 10. All other bits read 0. A read while `rd_en` is low, or at any other address, returns 0.
- R2: An accepted write with bit 15 at 0 loads the fields from these bits: loopback 14, speed 13, auto-negotiation enable 12, low power 11, isolate 10, full duplex 8, collision test 7. The matching outputs and read bits show the new values from the cycle after the write edge.
- R3: Bits 6..0 always read 0. Write data on those bits has no effect.
- R4: A write with bit 15 at 1 makes `soft_rst_busy` and read bit 15 equal 1 for exactly `RST_CYCLES` cycles, counted from the write edge. After that they return to 0.
- R5: A soft reset loads every field with its default. The other bits of the write that started it are discarded.
- R6: While the soft reset is busy, writes do not change any field and do not produce a restart request.
- R7: `sm_idle_req` is high for exactly the first cycle of each soft reset.
- R8: Writing 1 to bit 9 makes `an_restart_req` high for one cycle, and bit 9 reads 1 in that cycle only. Writing 0 to bit 9 gives no request.
- R9: Writes to any address other than `REG_ADDR` change nothing.
- R10: The isolate default is 1 when `phy_addr` is 5'b00000 and 0 for any other address. This holds for both hardware and soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| phy_addr | input | 5 | Strapped PHY address |
| reg_addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data (combinational) |
| ctl_loopback | output | 1 | Loopback mode |
| ctl_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ctl_an_enable | output | 1 | Auto-negotiation enabled |
| ctl_low_power | output | 1 | Low-power mode |
| ctl_isolate | output | 1 | Isolate from the MAC side |
| ctl_full_duplex | output | 1 | 1 = full duplex |
| ctl_col_test | output | 1 | Collision test |
| an_restart_req | output | 1 | One-cycle auto-negotiation restart request |
| sm_idle_req | output | 1 | One-cycle request to idle the other state machines |
| soft_rst_busy | output | 1 | Soft reset in progress |

## Verification
The assertions check the following on every cycle:
- each request output lasts a single cycle;
- each soft reset raises the idle request and busy together;
- the fields hold still while busy;
- the fields equal their defaults when busy rises;
- read bit 15 mirrors busy;
- the reserved bits stay at zero;
- the busy period is exactly `RST_CYCLES` long.

Some behaviour can only be shown by the bench's scenarios:
- the read values after a specific sequence of writes;
- that writes to a foreign address are dropped;
- that the isolate default follows a change of the strapped address across both kinds of reset.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned PADDR_W  = 5;

    localparam int unsigned B_SRST   = 15;
    localparam int unsigned B_LOOP   = 14;
    localparam int unsigned B_SPEED  = 13;
    localparam int unsigned B_ANEN   = 12;
    localparam int unsigned B_LPWR   = 11;
    localparam int unsigned B_ISO    = 10;
    localparam int unsigned B_ANRST  = 9;
    localparam int unsigned B_DUPLEX = 8;
    localparam int unsigned B_COLT   = 7;

    typedef struct packed {
        logic loopback;
        logic speed100;
        logic an_enable;
        logic low_power;
        logic isolate;
        logic full_duplex;
        logic col_test;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_KICK = 2'd1,
        RS_HOLD = 2'd2
    } rst_state_e;

    function automatic ctl_fields_t ctl_defaults(input logic [PADDR_W-1:0] strap);
        ctl_fields_t d;
        d.loopback    = 1'b0;
        d.speed100    = 1'b1;
        d.an_enable   = 1'b1;
        d.low_power   = 1'b0;
        d.isolate     = (strap == '0);
        d.full_duplex = 1'b0;
        d.col_test    = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/phy_ctrl_rst_fsm.sv
module phy_ctrl_rst_fsm
    import phy_ctrl_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic idle_req
);
    localparam int unsigned CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RST_CYCLES - 2);

    rst_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    initial begin
        if (RST_CYCLES < 2) $error("RST_CYCLES must be at least 2");
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (start) state_d = RS_KICK;
            RS_KICK: state_d = RS_HOLD;
            RS_HOLD: if (cnt_q == '0) state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RS_KICK)
                cnt_q <= HOLD_LOAD;
            else if (state_q == RS_HOLD && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy     = 1'b0;
        idle_req = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_KICK: begin
                busy     = 1'b1;
                idle_req = 1'b1;
            end
            RS_HOLD: busy = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/phy_ctrl_fields.sv
module phy_ctrl_fields
    import phy_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PADDR_W-1:0]  strap,
    input  logic                load_dflt,
    input  logic                wr_accept,
    input  logic [14:7]         wd,
    output ctl_fields_t         fields,
    output logic                restart
);
    ctl_fields_t f_q;
    logic        rs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q  <= ctl_defaults(strap);
            rs_q <= 1'b0;
        end else if (load_dflt) begin
            f_q  <= ctl_defaults(strap);
            rs_q <= 1'b0;
        end else if (wr_accept) begin
            f_q.loopback    <= wd[B_LOOP];
            f_q.speed100    <= wd[B_SPEED];
            f_q.an_enable   <= wd[B_ANEN];
            f_q.low_power   <= wd[B_LPWR];
            f_q.isolate     <= wd[B_ISO];
            f_q.full_duplex <= wd[B_DUPLEX];
            f_q.col_test    <= wd[B_COLT];
            rs_q            <= wd[B_ANRST];
        end else begin
            rs_q <= 1'b0;
        end
    end

    assign fields  = f_q;
    assign restart = rs_q;

endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned REG_ADDR   = 0,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    output logic              ctl_loopback,
    output logic              ctl_speed100,
    output logic              ctl_an_enable,
    output logic              ctl_low_power,
    output logic              ctl_isolate,
    output logic              ctl_full_duplex,
    output logic              ctl_col_test,
    output logic              an_restart_req,
    output logic              sm_idle_req,
    output logic              soft_rst_busy
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic        hit, wr_ok, start_rst, fld_wr, busy, idle_req, restart;
    ctl_fields_t fields;

    assign hit       = (reg_addr == MY_ADDR);
    assign wr_ok     = wr_en && hit && !busy;
    assign start_rst = wr_ok && wr_data[B_SRST];
    assign fld_wr    = wr_ok && !wr_data[B_SRST];

    phy_ctrl_rst_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_rst),
        .busy     (busy),
        .idle_req (idle_req)
    );

    phy_ctrl_fields u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (phy_addr),
        .load_dflt (start_rst),
        .wr_accept (fld_wr),
        .wd        (wr_data[14:7]),
        .fields    (fields),
        .restart   (restart)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en && hit) begin
            rd_data[B_SRST]   = busy;
            rd_data[B_LOOP]   = fields.loopback;
            rd_data[B_SPEED]  = fields.speed100;
            rd_data[B_ANEN]   = fields.an_enable;
            rd_data[B_LPWR]   = fields.low_power;
            rd_data[B_ISO]    = fields.isolate;
            rd_data[B_ANRST]  = restart;
            rd_data[B_DUPLEX] = fields.full_duplex;
            rd_data[B_COLT]   = fields.col_test;
        end
    end

    assign ctl_loopback    = fields.loopback;
    assign ctl_speed100    = fields.speed100;
    assign ctl_an_enable   = fields.an_enable;
    assign ctl_low_power   = fields.low_power;
    assign ctl_isolate     = fields.isolate;
    assign ctl_full_duplex = fields.full_duplex;
    assign ctl_col_test    = fields.col_test;
    assign an_restart_req  = restart;
    assign sm_idle_req     = idle_req;
    assign soft_rst_busy   = busy;

endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk #(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned REG_ADDR   = 0,
    parameter int unsigned RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        phy_addr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic [15:0]       wr_data,
    input logic              rd_en,
    input logic [15:0]       rd_data,
    input logic              ctl_loopback,
    input logic              ctl_speed100,
    input logic              ctl_an_enable,
    input logic              ctl_low_power,
    input logic              ctl_isolate,
    input logic              ctl_full_duplex,
    input logic              ctl_col_test,
    input logic              an_restart_req,
    input logic              sm_idle_req,
    input logic              soft_rst_busy
);
    localparam int unsigned LEN_W = $clog2(RST_CYCLES + 2);

    logic              sel, acc;
    logic [6:0]        flds;
    logic [LEN_W-1:0]  busy_len;

    assign sel  = (reg_addr == ADDR_W'(REG_ADDR));
    assign acc  = wr_en && sel && !soft_rst_busy;
    assign flds = {ctl_loopback, ctl_speed100, ctl_an_enable, ctl_low_power,
                   ctl_isolate, ctl_full_duplex, ctl_col_test};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             busy_len <= '0;
        else if (soft_rst_busy) busy_len <= busy_len + 1'b1;
        else                    busy_len <= '0;
    end

    p_idle_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sm_idle_req |=> !sm_idle_req);

    p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_req |=> !an_restart_req);

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_data[15]) |=> (soft_rst_busy && sm_idle_req));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst_busy) |-> (busy_len == LEN_W'(RST_CYCLES)));

    p_busy_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel) |-> (rd_data[15] == soft_rst_busy));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_busy |=> ($stable(flds) && !an_restart_req));

    p_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_busy) |-> (!ctl_loopback && ctl_speed100 && ctl_an_enable &&
            !ctl_low_power && !ctl_full_duplex && !ctl_col_test &&
            (ctl_isolate == (phy_addr == 5'd0))));

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr_data[15]) |=> (flds == {$past(wr_data[14:10]), $past(wr_data[8:7])}));

    p_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (wr_data[6:0] != 7'd0)) |=> (!rd_en || rd_data[6:0] == 7'd0));

    p_rsvd_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == 7'd0);

endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ctl_loopback(ctl_loopback), .ctl_speed100(ctl_speed100),
    .ctl_an_enable(ctl_an_enable), .ctl_low_power(ctl_low_power),
    .ctl_isolate(ctl_isolate), .ctl_full_duplex(ctl_full_duplex),
    .ctl_col_test(ctl_col_test), .an_restart_req(an_restart_req),
    .sm_idle_req(sm_idle_req), .soft_rst_busy(soft_rst_busy)
);

// File: tb/phy_ctrl_reg_bench.sv
`timescale 1ns/1ps
module phy_ctrl_reg_bench;
    localparam int RSTC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr = 5'd0;
    logic [4:0]  reg_addr = 5'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic ctl_loopback, ctl_speed100, ctl_an_enable, ctl_low_power;
    logic ctl_isolate, ctl_full_duplex, ctl_col_test;
    logic an_restart_req, sm_idle_req, soft_rst_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    phy_ctrl_reg #(.ADDR_W(5), .REG_ADDR(0), .RST_CYCLES(RSTC)) u_phy_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .ctl_loopback(ctl_loopback), .ctl_speed100(ctl_speed100),
        .ctl_an_enable(ctl_an_enable), .ctl_low_power(ctl_low_power),
        .ctl_isolate(ctl_isolate), .ctl_full_duplex(ctl_full_duplex),
        .ctl_col_test(ctl_col_test), .an_restart_req(an_restart_req),
        .sm_idle_req(sm_idle_req), .soft_rst_busy(soft_rst_busy)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; reg_addr = 5'd0;
    endtask

    // driver: pushes the expected word, strobes a read for one cycle
    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_addr = a; rd_en = 1'b1;
        cyc();
        rd_en = 1'b0; reg_addr = 5'd0;
    endtask

    // monitor: compares read data mid-cycle
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic hw_reset(input logic [4:0] strap);
        phy_addr = strap;
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        hw_reset(5'd0);
        // R1 R10: defaults with strap 0
        rd(5'd0, 16'h3400, "R1 reset word strap 0");
        check("R10 isolate out strap 0", {15'd0, ctl_isolate}, 16'd1);
        check("R1 busy idle at reset", {15'd0, soft_rst_busy}, 16'd0);
        rd(5'd4, 16'h0000, "R1 foreign read is zero");
        check("R1 no rd_en gives zero", rd_data, 16'h0000);

        // R2 R3: field writes, reserved bits ignored
        wr(5'd0, 16'h417F);
        check("R2 loopback out", {15'd0, ctl_loopback}, 16'd1);
        check("R2 duplex out", {15'd0, ctl_full_duplex}, 16'd1);
        check("R2 speed out", {15'd0, ctl_speed100}, 16'd0);
        rd(5'd0, 16'h4100, "R2 R3 readback 417F");
        wr(5'd0, 16'h0C80);
        rd(5'd0, 16'h0C80, "R2 readback 0C80");
        check("R2 low power out", {15'd0, ctl_low_power}, 16'd1);
        check("R2 col test out", {15'd0, ctl_col_test}, 16'd1);

        // R9: foreign address write
        wr(5'd3, 16'hFFFF);
        check("R9 no busy from foreign", {15'd0, soft_rst_busy}, 16'd0);
        check("R9 no restart from foreign", {15'd0, an_restart_req}, 16'd0);
        rd(5'd0, 16'h0C80, "R9 word unchanged");

        // R8: restart self-clear
        wr(5'd0, 16'h0E80);
        check("R8 restart pulse", {15'd0, an_restart_req}, 16'd1);
        rd(5'd0, 16'h0E80, "R8 bit9 live");
        check("R8 restart dropped", {15'd0, an_restart_req}, 16'd0);
        rd(5'd0, 16'h0C80, "R8 bit9 cleared");
        wr(5'd0, 16'h0C80);
        check("R8 write 0 no pulse", {15'd0, an_restart_req}, 16'd0);

        // R4 R5 R7: soft reset with other bits set
        wr(5'd0, 16'hC37F);
        check("R7 idle pulse first cycle", {15'd0, sm_idle_req}, 16'd1);
        check("R5 loopback discarded", {15'd0, ctl_loopback}, 16'd0);
        check("R8 no restart on soft reset", {15'd0, an_restart_req}, 16'd0);
        for (int k = 0; k <= RSTC; k++) begin
            check($sformatf("R4 busy cycle %0d", k), {15'd0, soft_rst_busy},
                  {15'd0, (k < RSTC) ? 1'b1 : 1'b0});
            if (k > 0)
                check($sformatf("R7 idle low cycle %0d", k), {15'd0, sm_idle_req}, 16'd0);
            if (k < RSTC) cyc();
        end
        rd(5'd0, 16'h3400, "R4 R5 word after soft reset");

        // R6 R10: strap 3, writes during busy dropped
        hw_reset(5'd3);
        rd(5'd0, 16'h3000, "R10 reset word strap 3");
        wr(5'd0, 16'h8000);
        wr(5'd0, 16'h4200);
        check("R6 no restart while busy", {15'd0, an_restart_req}, 16'd0);
        wr(5'd0, 16'h0D80);
        rd(5'd0, 16'hB000, "R6 R10 busy word");
        repeat (RSTC) cyc();
        rd(5'd0, 16'h3000, "R6 word after busy");
        check("R6 isolate kept default", {15'd0, ctl_isolate}, 16'd0);

        repeat (2) cyc();
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule